// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block observes the two wires of an I2C bus (clock and data) and turns their transitions into clean, single-cycle event pulses. It reports a Start, a Repeated Start and a Stop. It keeps a bus-busy level that is set by a Start and cleared by a Stop. Both lines first pass through a flop synchronizer. Edges are found by comparing each synchronized sample with the one before it.

A Stop or Repeated Start counts only after the clock line has been low at least once since the most recent Start. A short low pulse on the data line while the clock stays high therefore produces a Start and nothing more. The block also checks this node's own data drive. While the node says it is active on the bus and is releasing the data line, a low reading on that line is a collision. This covers another master pulling the line low before this node begins its own Start.

An interrupt request combines the three event pulses. A separate enable gates the Start and Repeated Start events, and another gates the Stop event. A mode input makes both enables irrelevant, so that every event interrupts.

Top module: `i2c_cond_detect`

## Requirements
- R1: When the bus is idle, a falling data line while the clock is high in both the current and the previous synchronized sample gives one `start_o` pulse and sets `busy_o`. Both outputs appear SYNC_STAGES+1 clock edges (3 with defaults) after the inputs change.
- R2: `start_o`, `rstart_o`, `stop_o` and `coll_o` are each high for exactly one clock cycle per event. At most one of the three bus event pulses is high in any cycle.
- R3: When the bus is busy and the clock has been low since the last Start or Repeated Start, a rising data line with the clock high gives one `stop_o` pulse and clears `busy_o`.
- R4: If the data line falls and then rises again while the clock stays high throughout, only the Start is reported. No Stop pulse follows, and `busy_o` stays high.
- R5: Under the same conditions that make a Stop valid, a falling data line with the clock high gives `rstart_o` and not `start_o`. `busy_o` stays high, and a later Stop again needs a clock low period first.
- R6: Data line changes while the clock is low produce no event pulse and leave `busy_o` unchanged.
- R7: `irq_o` is high in the same cycle as an event pulse. A Start or Repeated Start sets it when `start_ie_i` or `evt_mode_i` is 1. A Stop sets it when `stop_ie_i` or `evt_mode_i` is 1. Otherwise it is 0.
- R8: While `own_i` is 1 and `sda_oe_i` is 0 (the node is releasing the data line), a low synchronized data line gives one `coll_o` pulse, SYNC_STAGES+1 edges after the change. Pulling the line low with `sda_oe_i`=1, or holding `own_i`=0, gives no collision.
- R9: While `rst` is high and in the first cycle after it, all outputs are 0. The synchronizers treat both lines as high after reset, so release from reset creates no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| own_i | input | 1 | This node is active as a driver on the bus |
| sda_oe_i | input | 1 | This node pulls the data line low when 1 |
| start_ie_i | input | 1 | Interrupt enable for Start and Repeated Start |
| stop_ie_i | input | 1 | Interrupt enable for Stop |
| evt_mode_i | input | 1 | Mode that always interrupts on bus events |
| start_o | output | 1 | Start pulse |
| rstart_o | output | 1 | Repeated Start pulse |
| stop_o | output | 1 | Stop pulse |
| busy_o | output | 1 | Bus is held by a master |
| coll_o | output | 1 | Collision pulse |
| irq_o | output | 1 | Combined interrupt request |

## Verification
With defaults, every result follows its stimulus by exactly three rising edges. Two of these are synchronizer stages. The third is the output register that stores the event, the busy level, the collision pulse and the interrupt. The bench changes inputs on a falling edge, counts three rising edges, and samples on the next falling edge. It samples once more one cycle later to confirm that each pulse has dropped. The node's drive inputs are delayed by the same number of stages as the bus lines, so a release and the line's rise arrive together and cause no false collision.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic start;
        logic rstart;
        logic stop;
    } cond_ev_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_pair_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_HELD  = 2'd1,
        BUS_ARMED = 2'd2
    } bus_state_t;

    function automatic logic irq_fold(cond_ev_t ev, logic sie, logic pie, logic every);
        return ((ev.start | ev.rstart) & (sie | every)) | (ev.stop & (pie | every));
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned LANES   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [LANES-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] q
);
    logic [LANES-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= RST_VAL;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_cond_track.sv
module i2c_cond_track
    import i2c_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_pair_t now_i,
    output cond_ev_t  ev_nxt_o,
    output cond_ev_t  ev_o,
    output logic      busy_o
);
    bus_pair_t  prev;
    bus_state_t st, st_nxt;
    cond_ev_t   ev_nxt, ev_q;
    logic       scl_high, sda_fall, sda_rise;

    assign scl_high = now_i.scl & prev.scl;
    assign sda_fall = prev.sda & ~now_i.sda;
    assign sda_rise = ~prev.sda & now_i.sda;

    always_comb begin
        ev_nxt = '0;
        st_nxt = st;
        case (st)
            BUS_IDLE: begin
                if (scl_high && sda_fall) begin
                    ev_nxt.start = 1'b1;
                    st_nxt       = BUS_HELD;
                end
            end
            BUS_HELD: begin
                if (!now_i.scl) st_nxt = BUS_ARMED;
            end
            BUS_ARMED: begin
                if (scl_high && sda_fall) begin
                    ev_nxt.rstart = 1'b1;
                    st_nxt        = BUS_HELD;
                end else if (scl_high && sda_rise) begin
                    ev_nxt.stop = 1'b1;
                    st_nxt      = BUS_IDLE;
                end
            end
            default: st_nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '1;
            st   <= BUS_IDLE;
            ev_q <= '0;
        end else begin
            prev <= now_i;
            st   <= st_nxt;
            ev_q <= ev_nxt;
        end
    end

    assign ev_nxt_o = ev_nxt;
    assign ev_o     = ev_q;
    assign busy_o   = (st != BUS_IDLE);
endmodule

// File: rtl/i2c_drive_watch.sv
module i2c_drive_watch #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic own_i,
    input  logic oe_i,
    input  logic sda_s_i,
    output logic coll_o
);
    logic [1:0] drv_d;
    logic       mismatch, mis_q, coll_q;

    i2c_line_sync #(.LANES(2), .STAGES(STAGES), .RST_VAL(2'b00)) u_drv_dly (
        .clk (clk),
        .rst (rst),
        .d   ({own_i, oe_i}),
        .q   (drv_d)
    );

    assign mismatch = drv_d[1] & ~drv_d[0] & ~sda_s_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mis_q  <= 1'b0;
            coll_q <= 1'b0;
        end else begin
            mis_q  <= mismatch;
            coll_q <= mismatch & ~mis_q;
        end
    end

    assign coll_o = coll_q;
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_cond_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic own_i,
    input  logic sda_oe_i,
    input  logic start_ie_i,
    input  logic stop_ie_i,
    input  logic evt_mode_i,
    output logic start_o,
    output logic rstart_o,
    output logic stop_o,
    output logic busy_o,
    output logic coll_o,
    output logic irq_o
);
    bus_pair_t bus_s;
    cond_ev_t  ev_nxt, ev;
    logic      irq_q;

    i2c_line_sync #(.LANES(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (bus_s)
    );

    i2c_cond_track u_track (
        .clk      (clk),
        .rst      (rst),
        .now_i    (bus_s),
        .ev_nxt_o (ev_nxt),
        .ev_o     (ev),
        .busy_o   (busy_o)
    );

    i2c_drive_watch #(.STAGES(SYNC_STAGES)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .own_i   (own_i),
        .oe_i    (sda_oe_i),
        .sda_s_i (bus_s.sda),
        .coll_o  (coll_o)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_fold(ev_nxt, start_ie_i, stop_ie_i, evt_mode_i);
    end

    assign start_o  = ev.start;
    assign rstart_o = ev.rstart;
    assign stop_o   = ev.stop;
    assign irq_o    = irq_q;
endmodule

// File: rtl/i2c_cond_detect_chk.sv
module i2c_cond_detect_chk (
    input logic clk,
    input logic rst,
    input logic start_o,
    input logic rstart_o,
    input logic stop_o,
    input logic busy_o,
    input logic coll_o,
    input logic irq_o
);
    a_r1_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        start_o |-> (busy_o && $past(!busy_o)));

    a_r2_one_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_o, rstart_o, stop_o}));

    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    a_r3_stop_frees_bus: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> (!busy_o && $past(busy_o)));

    a_r5_rstart_keeps_busy: assert property (@(posedge clk) disable iff (rst)
        rstart_o |-> (busy_o && $past(busy_o)));

    a_r7_irq_needs_event: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (start_o || rstart_o || stop_o));

    a_r8_coll_single: assert property (@(posedge clk) disable iff (rst)
        coll_o |=> !coll_o);
endmodule

bind i2c_cond_detect i2c_cond_detect_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_o  (start_o),
    .rstart_o (rstart_o),
    .stop_o   (stop_o),
    .busy_o   (busy_o),
    .coll_o   (coll_o),
    .irq_o    (irq_o)
);

// File: tb/i2c_cond_detect_test.sv
module i2c_cond_detect_test;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_i = 1'b1, sda_i = 1'b1, own_i = 1'b0, sda_oe_i = 1'b0;
    logic start_ie_i = 1'b0, stop_ie_i = 1'b0, evt_mode_i = 1'b0;
    logic start_o, rstart_o, stop_o, busy_o, coll_o, irq_o;

    int run = 0;
    int failed = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_cond_detect uut (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .own_i(own_i),
        .sda_oe_i(sda_oe_i), .start_ie_i(start_ie_i), .stop_ie_i(stop_ie_i),
        .evt_mode_i(evt_mode_i), .start_o(start_o), .rstart_o(rstart_o),
        .stop_o(stop_o), .busy_o(busy_o), .coll_o(coll_o), .irq_o(irq_o)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        run++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; scl_i = 1'b1; sda_i = 1'b1; own_i = 1'b0; sda_oe_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive lines, then sample after LAT rising edges and once more a cycle later.
    task automatic step(logic scl, logic sda, logic es, logic er, logic ep,
                        logic eb, string tag);
        logic ei;
        ei = ((es | er) & (start_ie_i | evt_mode_i)) | (ep & (stop_ie_i | evt_mode_i));
        @(negedge clk);
        scl_i = scl; sda_i = sda;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        chk({tag, " events/busy/irq"},
            {4'b0, start_o, rstart_o, stop_o, busy_o},
            {4'b0, es, er, ep, eb});
        chk({tag, " R7 irq"}, {7'b0, irq_o}, {7'b0, ei});
        @(negedge clk);
        chk({tag, " R2 pulses dropped"},
            {4'b0, start_o, rstart_o, stop_o, irq_o}, 8'b0);
    endtask

    task automatic cstep(logic own, logic oe, logic sda, logic ec, string tag);
        @(negedge clk);
        own_i = own; sda_oe_i = oe; sda_i = sda;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        chk({tag, " R8 coll"}, {7'b0, coll_o}, {7'b0, ec});
        @(negedge clk);
        chk({tag, " R2 coll drop"}, {7'b0, coll_o}, 8'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            run++;
            failed++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", run, failed);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        chk("R9 outputs in reset",
            {2'b0, start_o, rstart_o, stop_o, busy_o, coll_o, irq_o}, 8'b0);
        do_reset();
        chk("R9 outputs after reset",
            {2'b0, start_o, rstart_o, stop_o, busy_o, coll_o, irq_o}, 8'b0);
        repeat (4) @(negedge clk);
        chk("R9 no event from release",
            {2'b0, start_o, rstart_o, stop_o, busy_o, coll_o, irq_o}, 8'b0);

        for (int c = 0; c < 8; c++) begin
            start_ie_i = c[0]; stop_ie_i = c[1]; evt_mode_i = c[2];
            step(1, 0, 1, 0, 0, 1, "R1 start");
            step(0, 0, 0, 0, 0, 1, "R6 scl low");
            step(0, 1, 0, 0, 0, 1, "R6 sda rise scl low");
            step(0, 0, 0, 0, 0, 1, "R6 sda fall scl low");
            step(0, 1, 0, 0, 0, 1, "R6 sda rise again");
            step(1, 1, 0, 0, 0, 1, "R6 scl high");
            step(1, 0, 0, 1, 0, 1, "R5 repeated start");
            step(1, 1, 0, 0, 0, 1, "R5 no stop before scl low");
            step(1, 0, 0, 0, 0, 1, "R5 fall without scl low");
            step(0, 0, 0, 0, 0, 1, "R3 scl low");
            step(1, 0, 0, 0, 0, 1, "R3 scl high");
            step(1, 1, 0, 0, 1, 0, "R3 stop");
            step(1, 0, 1, 0, 0, 1, "R4 glitch start");
            step(1, 1, 0, 0, 0, 1, "R4 glitch no stop");
            step(0, 1, 0, 0, 0, 1, "R4 cleanup scl low");
            step(0, 0, 0, 0, 0, 1, "R4 cleanup sda low");
            step(1, 0, 0, 0, 0, 1, "R4 cleanup scl high");
            step(1, 1, 0, 0, 1, 0, "R3 stop after glitch");
        end
        start_ie_i = 0; stop_ie_i = 0; evt_mode_i = 0;

        do_reset();
        cstep(1, 0, 0, 1, "R8 other master low before own start");
        do_reset();
        cstep(1, 1, 0, 0, "R8 own pull low");
        cstep(1, 0, 1, 0, "R8 own release with line");
        do_reset();
        cstep(0, 0, 0, 0, "R8 not owner");
        do_reset();
        cstep(1, 0, 1, 0, "R8 owner idle high");
        cstep(1, 0, 0, 1, "R8 line low while releasing");
        cstep(1, 0, 1, 0, "R8 line back high");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", run, failed);
        $finish;
    end
endmodule